// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits next to a MAC receive path and decides whether an incoming frame is kept. It reads the first six octets of the frame, which carry the destination address, from a byte stream. It then gives one registered verdict: accept or reject, plus a code that says which rule matched. Four rules are applied. A promiscuous setting keeps every frame. An exact match against the programmed station address keeps a unicast frame. The all-ones address is recognised as a broadcast. A group address is kept through a 64-bit hash filter that is indexed by the CRC-32 of the address.

A small mode register holds three control bits: promiscuous enable, broadcast disable and station-match disable. Writes to it take effect only while the controller reports a stopped or suspended state, so the filter rules cannot change while frames are live. The station address and the 64-bit hash filter come in as plain inputs from the surrounding controller. Octets that follow the destination address are ignored. This block does no frame buffering or CRC checking.

The byte input is a valid/ready stream that never applies back-pressure: `rx_ready` is high in every cycle, including during reset. An octet is consumed in each cycle where `rx_valid` is high. The producer may hold `rx_valid` low between octets for as long as it likes.

Top module: `rx_addr_filter`

## Requirements
- R1: When mode bit 0 (promiscuous) is set, every frame is accepted with match code 4, whatever its destination address.
- R2: With promiscuous clear and mode bit 2 clear, a unicast address (bit 0 of the first octet clear) equal to `sta_addr` is accepted with code 1. Any other unicast address is rejected with code 0. The first octet received maps to bits 7:0 of an address, the second to bits 15:8, and so on.
- R3: With promiscuous clear and mode bit 2 (station-match disable) set, a frame addressed to `sta_addr` is rejected with code 0.
- R4: With promiscuous clear and mode bit 1 clear, the all-ones address is accepted with code 2, whatever the hash filter holds.
- R5: With promiscuous clear and mode bit 1 (broadcast disable) set, the all-ones address is handled as an ordinary group address. It is accepted with code 3 when its hash filter bit is set, and rejected with code 0 otherwise.
- R6: A group address other than broadcast is accepted with code 3 exactly when `laf[k]` is set. The index k is bits 31:26 of a CRC register computed as follows. The register starts at all ones. The 48 address bits are shifted in from bit 0 upward. For each bit, the register is shifted right one place and XORed with 0xEDB88320 when the old bit 0 XOR the input bit is 1. No final inversion is applied. A unicast address never passes through the filter.
- R7: A write on `cfg_wr_en` updates the mode bits only when `stop_st` or `susp_st` is high. At any other time the write leaves `cfg_rd_data` unchanged.
- R8: The hard reset (`rst_n` low) and the soft reset (`soft_rst` high at a clock edge) both clear all mode bits, so broadcasts are received by default. `cfg_rd_data` bits 15:3 always read as zero.
- R9: An octet with `rx_sof` high starts a new address. `dec_valid` is high for exactly one cycle, in the cycle after the clock edge that follows the edge consuming the sixth octet. `dec_accept` is high exactly when the match code is non-zero.
- R10: Octets after the sixth, and octets that arrive with no preceding start, are ignored: `dec_valid` stays low, and `dec_accept` and `dec_kind` keep their last values until the next verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset of the mode bits |
| stop_st | input | 1 | Controller is stopped (mode writes allowed) |
| susp_st | input | 1 | Controller is suspended (mode writes allowed) |
| cfg_wr_en | input | 1 | Mode register write strobe |
| cfg_wr_data | input | 16 | Write data: bit 0 promiscuous, bit 1 broadcast disable, bit 2 station-match disable |
| cfg_rd_data | output | 16 | Mode register read value, reserved bits zero |
| sta_addr | input | 48 | Station address, first octet in bits 7:0 |
| laf | input | 64 | Multicast hash filter |
| rx_valid | input | 1 | Octet present on `rx_data` |
| rx_ready | output | 1 | Always high; no back-pressure |
| rx_sof | input | 1 | Marks the first octet of a frame |
| rx_data | input | 8 | Received octet |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Frame kept |
| dec_kind | output | 3 | Match code: 0 none, 1 station, 2 broadcast, 3 hash, 4 promiscuous |

## Verification
The sixth octet is consumed at one clock edge, and the verdict is registered at the next edge. The bench therefore checks at the falling edge after the sixth octet that `dec_valid` is still low. It then reads the verdict and its code at the following falling edge. A mode write lands at its own clock edge, so `cfg_rd_data` is read at the falling edge right after the write strobe. Extra octets are checked one falling edge after each of them is consumed, to confirm that no strobe appears and that the held verdict does not move.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned OCT_W = 8;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [2:0] {
    KIND_NONE    = 3'd0,
    KIND_STATION = 3'd1,
    KIND_BCAST   = 3'd2,
    KIND_HASH    = 3'd3,
    KIND_PROMISC = 3'd4
  } match_kind_e;

  typedef struct packed {
    logic no_station;
    logic no_bcast;
    logic promisc;
  } mode_t;

  function automatic logic [31:0] crc_octet(input logic [31:0] c_in,
                                            input logic [OCT_W-1:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < OCT_W; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY : 32'h0);
    end
    return c;
  endfunction

endpackage

// File: rtl/rx_mode_reg.sv
module rx_mode_reg
  import rxf_pkg::*;
#(
  parameter int unsigned CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             stop_st,
  input  logic             susp_st,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output mode_t            mode,
  output logic [CFG_W-1:0] rd_data
);
  localparam int unsigned MODE_W = $bits(mode_t);

  mode_t mode_q;
  logic  wr_ok;

  assign wr_ok = wr_en && (stop_st || susp_st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (soft_rst) begin
      mode_q <= '0;
    end else if (wr_ok) begin
      mode_q <= mode_t'(wr_data[MODE_W-1:0]);
    end
  end

  assign mode    = mode_q;
  assign rd_data = {{(CFG_W-MODE_W){1'b0}}, mode_q};
endmodule

// File: rtl/rx_addr_collect.sv
module rx_addr_collect
  import rxf_pkg::*;
#(
  parameter int unsigned N_OCT = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sof,
  input  logic [OCT_W-1:0]       in_data,
  output logic [N_OCT*OCT_W-1:0] addr,
  output logic [31:0]            crc,
  output logic                   done
);
  localparam int unsigned CNT_W = $clog2(N_OCT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_OCT - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(N_OCT);

  logic [CNT_W-1:0]       cnt_q;
  logic [N_OCT*OCT_W-1:0] addr_q;
  logic [31:0]            crc_q;
  logic                   done_q;
  logic                   take;
  logic [CNT_W-1:0]       slot;

  assign take = in_valid && (in_sof || (cnt_q != '0 && cnt_q != FULL));
  assign slot = in_sof ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      crc_q  <= '1;
      done_q <= 1'b0;
    end else begin
      done_q <= take && (slot == LAST);
      if (take) begin
        cnt_q <= slot + 1'b1;
        crc_q <= crc_octet(in_sof ? 32'hFFFF_FFFF : crc_q, in_data);
      end
    end
  end

  for (genvar g = 0; g < N_OCT; g++) begin : g_oct
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g*OCT_W +: OCT_W] <= '0;
      end else if (take && slot == CNT_W'(g)) begin
        addr_q[g*OCT_W +: OCT_W] <= in_data;
      end
    end
  end

  assign addr = addr_q;
  assign crc  = crc_q;
  assign done = done_q;
endmodule

// File: rtl/rx_addr_decide.sv
module rx_addr_decide
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 48,
  parameter int unsigned HASH_BITS = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  mode_t                   mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             crc,
  input  logic [ADDR_W-1:0]       sta_addr,
  input  logic [(1<<HASH_BITS)-1:0] laf,
  output logic                    out_valid,
  output logic                    out_accept,
  output match_kind_e             out_kind
);
  logic [HASH_BITS-1:0] hidx;
  logic                 is_group;
  logic                 is_bcast;
  logic                 is_own;
  logic                 hash_hit;
  match_kind_e          kind_d;

  assign hidx     = crc[31 -: HASH_BITS];
  assign is_group = addr[0];
  assign is_bcast = &addr;
  assign is_own   = (addr == sta_addr);
  assign hash_hit = laf[hidx];

  always_comb begin
    kind_d = KIND_NONE;
    if (mode.promisc) begin
      kind_d = KIND_PROMISC;
    end else if (!is_group) begin
      if (is_own && !mode.no_station) kind_d = KIND_STATION;
    end else if (is_bcast && !mode.no_bcast) begin
      kind_d = KIND_BCAST;
    end else if (hash_hit) begin
      kind_d = KIND_HASH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
      out_kind   <= KIND_NONE;
    end else begin
      out_valid <= start;
      if (start) begin
        out_accept <= (kind_d != KIND_NONE);
        out_kind   <= kind_d;
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned N_OCT     = 6,
  parameter int unsigned HASH_BITS = 6,
  parameter int unsigned CFG_W     = 16,
  localparam int unsigned ADDR_W   = N_OCT * OCT_W,
  localparam int unsigned LAF_W    = 1 << HASH_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop_st,
  input  logic              susp_st,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic [CFG_W-1:0]  cfg_rd_data,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic [LAF_W-1:0]  laf,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_sof,
  input  logic [OCT_W-1:0]  rx_data,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [2:0]        dec_kind
);
  mode_t             mode;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       crc;
  logic              done;
  match_kind_e       kind;

  assign rx_ready = 1'b1;

  rx_mode_reg #(.CFG_W(CFG_W)) mode_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .stop_st (stop_st),
    .susp_st (susp_st),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .mode    (mode),
    .rd_data (cfg_rd_data)
  );

  rx_addr_collect #(.N_OCT(N_OCT)) coll_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(rx_valid),
    .in_sof  (rx_sof),
    .in_data (rx_data),
    .addr    (addr),
    .crc     (crc),
    .done    (done)
  );

  rx_addr_decide #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) dec_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (done),
    .mode      (mode),
    .addr      (addr),
    .crc       (crc),
    .sta_addr  (sta_addr),
    .laf       (laf),
    .out_valid (dec_valid),
    .out_accept(dec_accept),
    .out_kind  (kind)
  );

  assign dec_kind = kind;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int unsigned CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             stop_st,
  input logic             susp_st,
  input logic             cfg_wr_en,
  input logic [CFG_W-1:0] cfg_rd_data,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic [2:0]       dec_kind
);
  a_r7_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !stop_st && !susp_st && !soft_rst) |=> $stable(cfg_rd_data));

  a_r8_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg_rd_data == '0));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[CFG_W-1:3] == '0);

  a_r9_accept_code: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_accept == (dec_kind != 3'd0)));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  a_r10_hold_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> ($stable(dec_kind) && $stable(dec_accept)));

  a_r1_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    dec_kind <= 3'd4);
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.CFG_W(CFG_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .stop_st    (stop_st),
  .susp_st    (susp_st),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_rd_data(cfg_rd_data),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .dec_kind   (dec_kind)
);

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;
  localparam realtime TCK = 4.0;

  localparam logic [47:0] A_OWN  = 48'hAB_89_67_45_23_02;
  localparam logic [47:0] A_MISS = 48'hAC_89_67_45_23_02;
  localparam logic [47:0] A_BC   = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] A_GRP  = 48'h00_00_00_5E_00_01;

  // {mode[2:0], dest[47:0], laf all ones, expected code[2:0]}
  localparam int NV = 16;
  localparam logic [54:0] VEC [NV] = '{
    {3'd0, A_OWN,  1'b0, 3'd1},
    {3'd0, A_MISS, 1'b0, 3'd0},
    {3'd0, A_BC,   1'b0, 3'd2},
    {3'd0, A_GRP,  1'b1, 3'd3},
    {3'd0, A_GRP,  1'b0, 3'd0},
    {3'd1, A_MISS, 1'b0, 3'd4},
    {3'd1, A_GRP,  1'b0, 3'd4},
    {3'd4, A_OWN,  1'b0, 3'd0},
    {3'd4, A_BC,   1'b0, 3'd2},
    {3'd2, A_BC,   1'b0, 3'd0},
    {3'd2, A_BC,   1'b1, 3'd3},
    {3'd2, A_OWN,  1'b0, 3'd1},
    {3'd6, A_OWN,  1'b1, 3'd0},
    {3'd6, A_GRP,  1'b1, 3'd3},
    {3'd7, A_OWN,  1'b0, 3'd4},
    {3'd5, A_BC,   1'b0, 3'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        stop_st = 1'b0;
  logic        susp_st = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic [47:0] sta_addr = A_OWN;
  logic [63:0] laf = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        rx_sof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        dec_valid;
  logic        dec_accept;
  logic [2:0]  dec_kind;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(TCK/2) clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_st(stop_st),
    .susp_st(susp_st), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .sta_addr(sta_addr), .laf(laf),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_sof(rx_sof),
    .rx_data(rx_data), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_kind(dec_kind)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] hash_of(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int b = 0; b < 48; b++) begin
      if (r[0] != a[b]) r = (r >> 1) ^ 32'hEDB88320;
      else              r = r >> 1;
    end
    return r[31:26];
  endfunction

  task automatic write_mode(input logic [15:0] v, input bit stp, input bit sus);
    @(negedge clk);
    stop_st = stp; susp_st = sus; cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0; stop_st = 1'b0; susp_st = 1'b0;
  endtask

  // Sends six octets; returns at the falling edge where the verdict is due.
  task automatic send_addr(input logic [47:0] a, input string req);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (k == 0); rx_data = a[8*k +: 8];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    check({req, " R9 early strobe"}, 48'(dec_valid), 48'd0);
    @(negedge clk);
    check({req, " R9 strobe"}, 48'(dec_valid), 48'd1);
  endtask

  task automatic expect_kind(input string req, input logic [2:0] k);
    check({req, " code"}, 48'(dec_kind), 48'(k));
    check({req, " R9 accept"}, 48'(dec_accept), 48'(k != 3'd0));
  endtask

  initial begin
    #(TCK * 100000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(TCK * 3.25);
    // R8: hard reset state
    check("R8 reset mode", 48'(cfg_rd_data), 48'd0);
    check("R9 reset strobe", 48'(dec_valid), 48'd0);
    check("R10 reset code", 48'(dec_kind), 48'd0);
    check("R9 ready", 48'(rx_ready), 48'd1);
    @(negedge clk); rst_n = 1'b1;

    // Vector table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [54:0] v = VEC[i];
      write_mode({13'd0, v[54:52]}, 1'b1, 1'b0);
      laf = v[3] ? '1 : '0;
      send_addr(v[51:4], $sformatf("R1-6 vec%0d", i));
      expect_kind($sformatf("vec%0d R2 R3 R4 R5", i), v[2:0]);
    end

    // R6: only the computed hash bit opens the filter
    write_mode(16'd0, 1'b1, 1'b0);
    laf = '0; laf[hash_of(A_GRP)] = 1'b1;
    send_addr(A_GRP, "R6 single bit");
    expect_kind("R6 single bit", 3'd3);
    laf = '1; laf[hash_of(A_GRP)] = 1'b0;
    send_addr(A_GRP, "R6 bit cleared");
    expect_kind("R6 bit cleared", 3'd0);
    // R5: broadcast via its own hash bit when broadcast is disabled
    write_mode(16'd2, 1'b0, 1'b1);
    laf = '0; laf[hash_of(A_BC)] = 1'b1;
    send_addr(A_BC, "R5 bcast hash");
    expect_kind("R5 bcast hash", 3'd3);

    // R10: trailing octets and stray octets change nothing
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'hFF;
      @(negedge clk); rx_valid = 1'b0;
      check("R10 trailing strobe", 48'(dec_valid), 48'd0);
      check("R10 trailing hold", 48'(dec_kind), 48'd3);
    end

    // R7: write outside stop/suspend is ignored, inside it lands
    write_mode(16'd5, 1'b0, 1'b0);
    check("R7 locked write", 48'(cfg_rd_data), 48'd2);
    write_mode(16'hFFFF, 1'b1, 1'b0);
    check("R8 reserved zero", 48'(cfg_rd_data), 48'h7);
    write_mode(16'd1, 1'b0, 1'b1);
    check("R7 suspend write", 48'(cfg_rd_data), 48'd1);

    // R8: soft reset clears the mode, broadcast then accepted
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R8 soft reset", 48'(cfg_rd_data), 48'd0);
    laf = '0;
    send_addr(A_BC, "R8 bcast default");
    expect_kind("R8 R4 bcast default", 3'd2);

    // R8: hard reset after setting broadcast disable
    write_mode(16'd2, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R8 hard reset", 48'(cfg_rd_data), 48'd0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule